// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a byte-addressed SPI master that runs one short serial-flash command for each software request. Before a command, software programs an opcode byte, a packed byte-count register and a serial clock rate. It then loads the outgoing bytes into an eight-entry ring buffer through a data port and sets a start bit. The engine pulls chip select low and shifts out the opcode. It then shifts out the requested number of bytes taken from the ring, followed by the requested number of read bytes. Every byte that follows the opcode is captured from the data-in line and written back into the ring entry it came from.

The ring is never cleared. Its three-bit pointer is visible to software and can be reset. The pointer advances by one for every data-port access and for every byte shifted after the opcode. At the end of a command the read data therefore sits in the entries just after the written bytes, and the pointer has moved by the sum of the two counts. Software resets the pointer, skips the write bytes and reads the response through the same data port.

The sequencer has four states. `ST_IDLE` holds chip select high. A start request moves it to `ST_LOW`. In `ST_LOW` the clock is low and the data-out bit is stable, and a divider tick moves it to `ST_HIGH` while sampling data-in. In `ST_HIGH` the clock is high, and a tick either moves to the next bit or byte (back to `ST_LOW`) or, after the last bit of the last byte, moves to `ST_DONE`. `ST_DONE` holds chip select low for one more half period, and its tick returns the sequencer to `ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sck` is low, the busy bit (offset 0x2 bit 0) reads 0 and the pointer (offset 0xD bits 2:0) reads 0.
- R2: When idle, a write to the data port (offset 0xC) stores the byte at the entry the pointer selects and advances the pointer modulo 8. After eight writes the pointer is back where it started.
- R3: When idle, a read of the data port (offset 0xC) returns the entry at the pointer and then advances the pointer by one.
- R4: Writing a 1 to bit 4 of offset 0x2 sets the pointer to 0. Software does not need to clear the bit.
- R5: Writing a 1 to bit 0 of offset 0x2 starts a command. While chip select is low, the engine shifts in SPI mode 0, MSB first (data changes while the clock is low and is sampled on the rising edge). It sends the opcode at offset 0x0 first, then the write-count bytes taken from the ring starting at the pointer, then the read-count bytes, and nothing else.
- R6: Each byte after the opcode is replaced in the ring by the byte received during it, and the pointer ends advanced by write count plus read count modulo 8. Read data therefore lands in the entries that follow the written bytes.
- R7: The busy bit reads 1 while a command runs and clears itself afterwards, and chip select returns high.
- R8: Offset 0x1 holds the read count in bits 7:4 and the write count in bits 3:0. It reads back unchanged after a command.
- R9: Offset 0xD bits 5:4 select the rate. Encoding n makes each clock half period n+1 system clocks, so 0 is the fastest.
- R10: While a command runs, writes to the opcode, the count register, the data port and the pointer-reset bit are ignored.
- R11: A count field above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (advances the pointer on the data port) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two agents can reach the ring in the same cycle: the sequencer storing a received byte at the end of a bit period, and software writing the data port or the pointer-reset bit. The bench provokes this by issuing opcode, count, data-port and pointer-reset writes in the middle of a slow command. It then reads back the opcode, the count register, the pointer and all eight entries, and compares them with a model in which only the sequencer has written. A scoreboard also compares every serial byte with the expected sequence, including commands that start from a non-zero pointer and wrap around the ring.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } seq_state_t;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNT  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_STAT   = 4'hD;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 4;
    localparam int STAT_SEL_LSB = 4;
endpackage

// File: rtl/spi_cmd_ring.sv
module spi_cmd_ring #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [PW-1:0] ptr,
    output logic [DW-1:0] rd_cur,
    output logic [DW-1:0] rd_next
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr_nx;

    assign ptr_nx  = ptr + 1'b1;
    assign rd_cur  = mem[ptr];
    assign rd_next = mem[ptr_nx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (clr) begin
                ptr <= '0;
            end else if (adv) begin
                ptr <= ptr_nx;
            end
            if (wr_en) begin
                mem[ptr] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [SEL_W-1:0] cnt;

    assign tick = en && (cnt == sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 4,
    parameter int MAXB  = 8,
    localparam int LW   = $clog2(2 * MAXB + 1),
    localparam int BW   = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    opcode,
    input  logic [CNT_W-1:0] wcnt,
    input  logic [CNT_W-1:0] rcnt,
    input  logic             tick,
    input  logic             miso,
    input  logic [DW-1:0]    ring_cur,
    input  logic [DW-1:0]    ring_next,
    output logic             busy,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi,
    output logic             ring_wr,
    output logic [DW-1:0]    ring_wdata
);
    seq_state_t    state, state_nx;
    logic [DW-1:0] sh;
    logic          samp;
    logic [BW-1:0] bitcnt;
    logic [LW-1:0] left;
    logic          is_op;
    logic [LW-1:0] wsat, rsat;
    logic          last_bit;

    assign wsat     = (LW'(wcnt) > LW'(MAXB)) ? LW'(MAXB) : LW'(wcnt);
    assign rsat     = (LW'(rcnt) > LW'(MAXB)) ? LW'(MAXB) : LW'(rcnt);
    assign last_bit = (bitcnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOW;
            ST_LOW:  if (tick)  state_nx = ST_HIGH;
            ST_HIGH: if (tick)  state_nx = (last_bit && left == '0) ? ST_DONE : ST_LOW;
            ST_DONE: if (tick)  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            samp   <= 1'b0;
            bitcnt <= '0;
            left   <= '0;
            is_op  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                sh     <= opcode;
                bitcnt <= BW'(DW - 1);
                left   <= wsat + rsat;
                is_op  <= 1'b1;
            end else if (state == ST_LOW && tick) begin
                samp <= miso;
            end else if (state == ST_HIGH && tick) begin
                if (!last_bit) begin
                    sh     <= {sh[DW-2:0], samp};
                    bitcnt <= bitcnt - 1'b1;
                end else begin
                    bitcnt <= BW'(DW - 1);
                    is_op  <= 1'b0;
                    if (left != '0) begin
                        left <= left - 1'b1;
                        sh   <= is_op ? ring_cur : ring_next;
                    end
                end
            end
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        cs_n       = (state == ST_IDLE);
        sck        = (state == ST_HIGH);
        mosi       = (state == ST_IDLE) ? 1'b0 : sh[DW-1];
        ring_wr    = (state == ST_HIGH) && tick && last_bit && !is_op;
        ring_wdata = {sh[DW-2:0], samp};
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int SEL_W = 2,
    parameter int MAXB  = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    logic [DW-1:0]        opcode_q;
    logic [2*CNT_W-1:0]   count_q;
    logic [SEL_W-1:0]     speed_q;
    logic                 busy;
    logic                 tick;
    logic                 seq_wr;
    logic [DW-1:0]        seq_wdata;
    logic [PW-1:0]        ring_ptr;
    logic [DW-1:0]        ring_cur, ring_next;
    logic                 ctrl_wr, start, ptr_clr;
    logic                 data_wr, data_rd;
    logic                 ring_wr, ring_adv;
    logic [DW-1:0]        ring_wdata;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL) && !busy;
    assign start   = ctrl_wr && bus_wdata[CTRL_GO_BIT];
    assign ptr_clr = ctrl_wr && bus_wdata[CTRL_CLR_BIT];
    assign data_wr = bus_wr && (bus_addr == OFS_DATA) && !busy;
    assign data_rd = bus_rd && (bus_addr == OFS_DATA) && !busy;

    assign ring_wr    = busy ? seq_wr : data_wr;
    assign ring_wdata = busy ? seq_wdata : bus_wdata;
    assign ring_adv   = ring_wr || data_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= '0;
            count_q  <= '0;
            speed_q  <= '0;
        end else begin
            if (bus_wr && !busy && bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
            if (bus_wr && !busy && bus_addr == OFS_COUNT)  count_q  <= bus_wdata[2*CNT_W-1:0];
            if (bus_wr && bus_addr == OFS_STAT)            speed_q  <= bus_wdata[STAT_SEL_LSB +: SEL_W];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_OPCODE: bus_rdata = opcode_q;
            OFS_COUNT:  bus_rdata = DW'(count_q);
            OFS_CTRL:   bus_rdata[CTRL_GO_BIT] = busy;
            OFS_DATA:   bus_rdata = ring_cur;
            OFS_STAT: begin
                bus_rdata[PW-1:0]                 = ring_ptr;
                bus_rdata[STAT_SEL_LSB +: SEL_W]  = speed_q;
            end
            default:    bus_rdata = '0;
        endcase
    end

    spi_cmd_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ptr_clr),
        .adv     (ring_adv),
        .wr_en   (ring_wr),
        .wr_data (ring_wdata),
        .ptr     (ring_ptr),
        .rd_cur  (ring_cur),
        .rd_next (ring_next)
    );

    spi_cmd_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .sel   (speed_q),
        .tick  (tick)
    );

    spi_cmd_seq #(.DW(DW), .CNT_W(CNT_W), .MAXB(MAXB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode_q),
        .wcnt       (count_q[CNT_W-1:0]),
        .rcnt       (count_q[2*CNT_W-1:CNT_W]),
        .tick       (tick),
        .miso       (spi_miso),
        .ring_cur   (ring_cur),
        .ring_next  (ring_next),
        .busy       (busy),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .ring_wr    (seq_wr),
        .ring_wdata (seq_wdata)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
#(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cs_n,
    input logic          sck,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [3:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [PW-1:0] ptr,
    input logic [7:0]    opcode_q,
    input logic [7:0]    count_q
);
    a_r5_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r4_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == OFS_CTRL && bus_wdata[CTRL_CLR_BIT]) |=> (ptr == '0));

    a_r2_ptr_steps_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == OFS_DATA) |=> (ptr == $past(ptr) + 1'b1));

    a_r10_opcode_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opcode_q));

    a_r8_count_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(count_q));

    a_r6_ptr_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_wr && !bus_rd) |=> $stable(ptr));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PW(3)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ptr       (ring_ptr),
    .opcode_q  (opcode_q),
    .count_q   (count_q)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int tests = 0;
    int fails = 0;

    logic [7:0] mring [8];
    int         mptr = 0;
    logic [7:0] exp_q [$];
    logic [7:0] resp_base = 8'h00;
    int         sbit = 0;
    int         sbyte = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] resp_byte;
    realtime    t_rise = 0;
    realtime    hi_w = 0;

    always #2 clk = ~clk;

    spi_cmd_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    assign resp_byte = resp_base + 8'(sbyte);
    assign spi_miso  = resp_byte[3'(7 - sbit)];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: slave model and serial byte comparison
    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (spi_sck) begin
            t_rise = $realtime;
            cur = {cur[6:0], spi_mosi};
            sbit++;
            if (sbit == 8) begin
                sbit = 0;
                sbyte++;
                if (exp_q.size() == 0) begin
                    chk("R5 extra serial byte", cur, 8'hxx);
                end else begin
                    chk("R5 serial byte", cur, exp_q.pop_front());
                end
            end
        end else begin
            sbit  = 0;
            sbyte = 0;
        end
    end

    always @(negedge spi_sck) hi_w = $realtime - t_rise;

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_ring(input string tag);
        logic [7:0] v;
        wr(4'h2, 8'h10);
        mptr = 0;
        for (int i = 0; i < 8; i++) begin
            rd(4'hC, v);
            chk(tag, v, mring[i]);
        end
        rd(4'hD, v);
        chk("R3 pointer after eight reads", v & 8'h07, 8'h00);
    endtask

    task automatic run_txn(input logic [7:0] opc, input int w, input int r,
                           input logic [7:0] base, input int sel, input bit inject);
        int ws, rs, tot;
        logic [7:0] v;
        ws = (w > 8) ? 8 : w;
        rs = (r > 8) ? 8 : r;
        tot = ws + rs;
        exp_q.push_back(opc);
        for (int i = 0; i < tot; i++) exp_q.push_back(mring[(mptr + i) % 8]);
        for (int k = 1; k <= tot; k++) mring[(mptr + k - 1) % 8] = base + 8'(k);
        mptr = (mptr + tot) % 8;
        resp_base = base;
        wr(4'hD, 8'(sel << 4));
        wr(4'h1, 8'({r[3:0], w[3:0]}));
        wr(4'h0, opc);
        wr(4'h2, 8'h01);
        rd(4'h2, v);
        chk("R7 busy while running", v & 8'h01, 8'h01);
        if (inject) begin
            wr(4'h0, 8'hEE);
            wr(4'h1, 8'h77);
            wr(4'hC, 8'h99);
            wr(4'h2, 8'h10);
        end
        for (int n = 0; n < 4000; n++) begin
            rd(4'h2, v);
            if (v[0] == 1'b0) break;
        end
        chk("R7 busy clears", v & 8'h01, 8'h00);
        chk("R7 cs high after", {7'd0, spi_cs_n}, 8'h01);
        chk("R5 all bytes sent", 8'(exp_q.size()), 8'h00);
        exp_q.delete();
        rd(4'h0, v);
        chk("R10 opcode kept", v, opc);
        rd(4'h1, v);
        chk("R8 count readback", v, 8'({r[3:0], w[3:0]}));
        rd(4'hD, v);
        chk("R6 pointer advanced", v & 8'h07, 8'(mptr));
        chk("R9 rate field readback", (v >> 4) & 8'h03, 8'(sel));
        chk("R9 clock high width", 8'(int'(hi_w)), 8'((sel + 1) * 4));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) mring[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 cs high", {7'd0, spi_cs_n}, 8'h01);
        chk("R1 sck low", {7'd0, spi_sck}, 8'h00);
        rst_n = 1'b1;
        rd(4'h2, v);
        chk("R1 busy clear", v, 8'h00);
        rd(4'hD, v);
        chk("R1 pointer zero", v & 8'h07, 8'h00);

        // R2: fill and wrap
        for (int i = 0; i < 8; i++) begin
            wr(4'hC, 8'h10 + 8'(i));
            mring[i] = 8'h10 + 8'(i);
        end
        rd(4'hD, v);
        chk("R2 pointer wrapped", v & 8'h07, 8'h00);
        wr(4'hC, 8'h5A);
        mring[0] = 8'h5A;
        rd(4'hD, v);
        chk("R2 pointer after ninth write", v & 8'h07, 8'h01);

        // R4 then R3
        wr(4'h2, 8'h10);
        rd(4'hD, v);
        chk("R4 pointer reset", v & 8'h07, 8'h00);
        rd(4'hC, v);
        chk("R3 first read", v, 8'h5A);
        rd(4'hD, v);
        chk("R3 pointer after read", v & 8'h07, 8'h01);
        check_ring("R3 ring contents");

        // R5/R6: write then read phase, fastest rate
        run_txn(8'h9F, 3, 2, 8'h40, 0, 1'b0);
        check_ring("R6 ring after command");

        // opcode only
        mptr = 0;
        run_txn(8'h06, 0, 0, 8'h60, 1, 1'b0);

        // start from pointer 6 and wrap around
        for (int i = 0; i < 6; i++) rd(4'hC, v);
        mptr = 6;
        run_txn(8'h0B, 2, 3, 8'h80, 2, 1'b0);
        check_ring("R6 ring after wrap");

        // R10: writes during a slow command are ignored
        mptr = 0;
        run_txn(8'h03, 2, 1, 8'hA0, 3, 1'b1);
        check_ring("R10 ring untouched by bus");

        // R11: oversized write count
        mptr = 0;
        run_txn(8'h02, 15, 0, 8'hC0, 0, 1'b0);
        check_ring("R11 ring after saturated count");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule